// File: doc/BRIEF.md
# Strict-Priority and Weighted Round-Robin Egress Scheduler

This block sits at one egress port and chooses which of four packet queues sends next. The highest queue (index 3) has absolute priority: if it holds a packet when a choice is made, it wins. Queues 0 to 2 share whatever link time is left by weighted round-robin. Each of them has a 4-bit weight that gives the number of packets it may send in one round. A weight of zero takes the queue out of the rotation. Choices are made only when the link is idle, that is, after the end-of-packet of the previous grant, so a packet in flight is never pre-empted.

The block also handles the enqueue side. An arriving packet carries a 3-bit class of service. A programmable map turns that class into a queue index. For the three lower queues, an early-drop test then compares the queue's present occupancy with a low and a high threshold. Below the low threshold the packet is kept. At or above the high threshold it is dropped. Between the two thresholds, a free-running pseudo-random value decides against a per-queue probability. Queue 3 never drops.

Top module: `egs_sched`

## Requirements
- R1: The enqueue queue index `enq_qid_o` equals bits [2c+1:2c] of `cos_map_i` for class c on `enq_cos_i`. The output is combinational, in the same cycle.
- R2: A choice is made on a clock edge where the link is idle and some queue qualifies. If `q_ready_i[3]` is 1 at that edge, the grant names queue 3.
- R3: Weights sit at `wt_i[4i+3:4i]` for lower queue i, and a lower queue can win only if `q_ready_i[3]` is 0. Within a round, a ready lower queue with nonzero weight w receives w grants, and the lowest qualifying index is served first. A new round, which reloads every credit from its weight, starts when no ready queue with nonzero weight has credit left.
- R4: A lower queue whose weight is zero is never granted.
- R5: A grant names only a queue whose `q_ready_i` bit was 1 at the deciding edge. No grant is issued while no queue qualifies.
- R6: `grant_valid_o` is a one-cycle pulse, registered one edge after the deciding edge. After a grant, no further grant is issued until `eop_i` has been seen high on a clock edge. The next choice is made on the following edge.
- R7: An enqueue to lower queue q whose occupancy (`occ_i[10q+9:10q]`) is below that queue's low threshold is never dropped.
- R8: An enqueue to lower queue q whose occupancy is at or above that queue's high threshold is always dropped, whatever the probability.
- R9: In the band between the thresholds, a drop happens when the 8-bit pseudo-random value is below `prob_i[8q+7:8q]`. That value steps once per enqueue cycle through all of 1..255. Probability 0 never drops, and 255 back-to-back in-band enqueues at probability p give exactly p-1 drops.
- R10: Enqueues mapped to queue 3 are never dropped.
- R11: After reset, no grant is pending and all credits are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cos_map_i | input | 16 | Class-to-queue map, 2 bits per class |
| wt_i | input | 12 | Round-robin weights of queues 0..2, 4 bits each |
| thr_lo_i | input | 30 | Low drop thresholds of queues 0..2 |
| thr_hi_i | input | 30 | High drop thresholds of queues 0..2 |
| prob_i | input | 24 | In-band drop probabilities of queues 0..2 |
| enq_valid_i | input | 1 | Enqueue request this cycle |
| enq_cos_i | input | 3 | Class of service of the request |
| occ_i | input | 30 | Present occupancy of queues 0..2 |
| enq_qid_o | output | 2 | Queue chosen for the request |
| enq_drop_o | output | 1 | Request is dropped |
| q_ready_i | input | 4 | Queue holds a packet, one bit per queue |
| eop_i | input | 1 | Granted packet has finished |
| grant_valid_o | output | 1 | Grant pulse |
| grant_q_o | output | 2 | Queue granted |

## Verification
The scheduler is first driven with all three lower queues ready and unequal weights, which shows whether grant counts follow the weights and whether the in-round order is right. Raising the strict queue alongside the others checks that it wins every choice and leaves the credits untouched. A zero weight and a sparse ready pattern show whether excluded or idle queues are skipped and whether a new round starts early when it should. The link is held busy with the strict queue ready, and no queue is ready after release, which shows that no grant is issued early or spuriously. On the enqueue side, two different class maps distinguish the field positions. Occupancies one below the low threshold, at the high threshold, and inside the band with probabilities 0, 128 and 255 separate the three drop regions.

// File: rtl/egs_pkg.sv
package egs_pkg;
  localparam int NQ      = 4;
  localparam int NLQ     = NQ - 1;
  localparam int QID_W   = $clog2(NQ);
  localparam int COS_W   = 3;
  localparam int NCOS    = 1 << COS_W;
  localparam int LFSR_W  = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;
  localparam int OCC_W_D  = 10;
  localparam int WT_W_D   = 4;
  localparam int PROB_W_D = 8;

  typedef enum logic {ST_IDLE, ST_BUSY} sched_st_e;
  typedef logic [QID_W-1:0] qid_t;
endpackage

// File: rtl/egs_lfsr.sv
module egs_lfsr
  import egs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] value_o
);
  logic [LFSR_W-1:0] st_q;
  logic              fb;

  assign fb      = ^(st_q & LFSR_TAPS);
  assign value_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= LFSR_SEED;
    else if (step_i) st_q <= {st_q[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/egs_enq_filter.sv
module egs_enq_filter
  import egs_pkg::*;
#(
  parameter int OCC_W  = OCC_W_D,
  parameter int PROB_W = PROB_W_D
)(
  input  logic                    valid_i,
  input  logic [COS_W-1:0]        cos_i,
  input  logic [NCOS*QID_W-1:0]   cos_map_i,
  input  logic [NLQ*OCC_W-1:0]    occ_i,
  input  logic [NLQ*OCC_W-1:0]    thr_lo_i,
  input  logic [NLQ*OCC_W-1:0]    thr_hi_i,
  input  logic [NLQ*PROB_W-1:0]   prob_i,
  input  logic [LFSR_W-1:0]       rnd_i,
  output qid_t                    qid_o,
  output logic                    drop_o
);
  localparam int RW = (PROB_W > LFSR_W) ? PROB_W : LFSR_W;

  logic [NLQ-1:0] verdict;

  assign qid_o = cos_map_i[int'(cos_i)*QID_W +: QID_W];

  for (genvar i = 0; i < NLQ; i++) begin : g_q
    logic [OCC_W-1:0]  occ, lo, hi;
    logic [PROB_W-1:0] pr;
    assign occ = occ_i[i*OCC_W +: OCC_W];
    assign lo  = thr_lo_i[i*OCC_W +: OCC_W];
    assign hi  = thr_hi_i[i*OCC_W +: OCC_W];
    assign pr  = prob_i[i*PROB_W +: PROB_W];
    always_comb begin
      if (occ >= hi)     verdict[i] = 1'b1;
      else if (occ < lo) verdict[i] = 1'b0;
      else               verdict[i] = RW'(rnd_i) < RW'(pr);
    end
  end

  always_comb begin
    drop_o = 1'b0;
    for (int i = 0; i < NLQ; i++)
      if (qid_o == QID_W'(i)) drop_o = valid_i & verdict[i];
  end
endmodule

// File: rtl/egs_wrr.sv
module egs_wrr
  import egs_pkg::*;
#(
  parameter int WT_W = WT_W_D
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NLQ-1:0]      ready_i,
  input  logic [NLQ*WT_W-1:0] wt_i,
  input  logic                take_i,
  output logic                pick_valid_o,
  output qid_t                pick_q_o
);
  logic [WT_W-1:0] cr_q [NLQ];
  logic [NLQ-1:0]  elig, live, cand;
  logic            reload;

  for (genvar i = 0; i < NLQ; i++) begin : g_el
    assign live[i] = ready_i[i] & (|wt_i[i*WT_W +: WT_W]);
    assign elig[i] = live[i] & (|cr_q[i]);
  end

  assign reload       = ~(|elig) & (|live);
  assign cand         = reload ? live : elig;
  assign pick_valid_o = |cand;

  always_comb begin
    pick_q_o = '0;
    for (int i = NLQ - 1; i >= 0; i--)
      if (cand[i]) pick_q_o = QID_W'(i);
  end

  for (genvar i = 0; i < NLQ; i++) begin : g_cr
    logic [WT_W-1:0] base;
    assign base = reload ? wt_i[i*WT_W +: WT_W] : cr_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cr_q[i] <= '0;
      else if (take_i && pick_valid_o)
        cr_q[i] <= (pick_q_o == QID_W'(i)) ? base - 1'b1 : base;
    end
  end
endmodule

// File: rtl/egs_sched.sv
module egs_sched
  import egs_pkg::*;
#(
  parameter int OCC_W  = OCC_W_D,
  parameter int WT_W   = WT_W_D,
  parameter int PROB_W = PROB_W_D
)(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCOS*QID_W-1:0] cos_map_i,
  input  logic [NLQ*WT_W-1:0]   wt_i,
  input  logic [NLQ*OCC_W-1:0]  thr_lo_i,
  input  logic [NLQ*OCC_W-1:0]  thr_hi_i,
  input  logic [NLQ*PROB_W-1:0] prob_i,
  input  logic                  enq_valid_i,
  input  logic [COS_W-1:0]      enq_cos_i,
  input  logic [NLQ*OCC_W-1:0]  occ_i,
  output logic [QID_W-1:0]      enq_qid_o,
  output logic                  enq_drop_o,
  input  logic [NQ-1:0]         q_ready_i,
  input  logic                  eop_i,
  output logic                  grant_valid_o,
  output logic [QID_W-1:0]      grant_q_o
);
  logic [LFSR_W-1:0] rnd;
  sched_st_e         st_q;
  logic              strict, lo_valid, idle, decide;
  qid_t              lo_q;

  egs_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (enq_valid_i),
    .value_o (rnd)
  );

  egs_enq_filter #(.OCC_W(OCC_W), .PROB_W(PROB_W)) u_filt (
    .valid_i   (enq_valid_i),
    .cos_i     (enq_cos_i),
    .cos_map_i (cos_map_i),
    .occ_i     (occ_i),
    .thr_lo_i  (thr_lo_i),
    .thr_hi_i  (thr_hi_i),
    .prob_i    (prob_i),
    .rnd_i     (rnd),
    .qid_o     (enq_qid_o),
    .drop_o    (enq_drop_o)
  );

  assign idle   = (st_q == ST_IDLE);
  assign strict = q_ready_i[NQ-1];
  assign decide = idle & (strict | lo_valid);

  egs_wrr #(.WT_W(WT_W)) u_wrr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ready_i      (q_ready_i[NLQ-1:0]),
    .wt_i         (wt_i),
    .take_i       (idle & ~strict),
    .pick_valid_o (lo_valid),
    .pick_q_o     (lo_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      grant_valid_o <= 1'b0;
      grant_q_o     <= '0;
    end else begin
      grant_valid_o <= decide;
      if (decide) begin
        grant_q_o <= strict ? QID_W'(NQ-1) : lo_q;
        st_q      <= ST_BUSY;
      end else if (!idle && eop_i) begin
        st_q      <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/egs_sched_chk.sv
module egs_sched_chk
  import egs_pkg::*;
#(
  parameter int WT_W = WT_W_D
)(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NLQ*WT_W-1:0] wt_i,
  input logic [NQ-1:0]       q_ready_i,
  input logic                eop_i,
  input logic                enq_valid_i,
  input logic [QID_W-1:0]    enq_qid_o,
  input logic                enq_drop_o,
  input logic                grant_valid_o,
  input logic [QID_W-1:0]    grant_q_o
);
  logic inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= 1'b0;
    else         inflight_q <= (inflight_q | grant_valid_o) & ~eop_i;
  end

  a_r2_strict_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && $past(q_ready_i[NQ-1]) |-> grant_q_o == QID_W'(NQ-1));

  a_r4_zero_weight_skipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && grant_q_o != QID_W'(NQ-1)
      |-> (($past(wt_i) >> (int'(grant_q_o) * WT_W)) & {{(NLQ*WT_W-WT_W){1'b0}}, {WT_W{1'b1}}}) != '0);

  a_r5_granted_was_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (($past(q_ready_i) >> grant_q_o) & 4'b0001) != '0);

  a_r6_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> !inflight_q);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |=> !grant_valid_o);

  a_r10_top_never_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_valid_i && enq_qid_o == QID_W'(NQ-1) |-> !enq_drop_o);
endmodule

bind egs_sched egs_sched_chk #(.WT_W(WT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wt_i          (wt_i),
  .q_ready_i     (q_ready_i),
  .eop_i         (eop_i),
  .enq_valid_i   (enq_valid_i),
  .enq_qid_o     (enq_qid_o),
  .enq_drop_o    (enq_drop_o),
  .grant_valid_o (grant_valid_o),
  .grant_q_o     (grant_q_o)
);

// File: tb/sim_egs_sched.sv
module sim_egs_sched;
  localparam int CLK = 10;
  localparam int OW  = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] cos_map_i = '0;
  logic [11:0] wt_i = '0;
  logic [29:0] thr_lo_i = '0, thr_hi_i = '0, occ_i = '0;
  logic [23:0] prob_i = '0;
  logic        enq_valid_i = 1'b0;
  logic [2:0]  enq_cos_i = '0;
  logic [1:0]  enq_qid_o;
  logic        enq_drop_o;
  logic [3:0]  q_ready_i = '0;
  logic        eop_drv = 1'b0, eop_mon = 1'b0, eop_i;
  logic        grant_valid_o;
  logic [1:0]  grant_q_o;

  int total = 0, bad = 0;
  int exp_q[$];
  int mcr[3];
  int mwt[3];
  bit done = 0;

  assign eop_i = eop_drv | eop_mon;

  always #(CLK/2) clk_i = ~clk_i;

  egs_sched u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare grants, answer with end-of-packet while more are expected
  always @(negedge clk_i) begin
    eop_mon = 1'b0;
    if (rst_ni && grant_valid_o) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected grant", grant_q_o, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(grant_q_o == 2'(e), "R3 grant order", grant_q_o, e);
        if (exp_q.size() != 0) eop_mon = 1'b1;
      end
    end
  end

  task automatic set_wt(input int a, input int b, input int c);
    mwt[0] = a; mwt[1] = b; mwt[2] = c;
    wt_i = {4'(c), 4'(b), 4'(a)};
  endtask

  // expected grants from R2/R3/R4
  task automatic push_n(input int n, input logic [3:0] rdy);
    for (int k = 0; k < n; k++) begin
      int sel;
      bit any;
      sel = -1;
      if (rdy[3]) sel = 3;
      else begin
        for (int i = 2; i >= 0; i--)
          if (rdy[i] && mwt[i] > 0 && mcr[i] > 0) sel = i;
        if (sel < 0) begin
          any = 0;
          for (int i = 0; i < 3; i++) if (rdy[i] && mwt[i] > 0) any = 1;
          if (any) begin
            for (int i = 0; i < 3; i++) mcr[i] = mwt[i];
            for (int i = 2; i >= 0; i--) if (rdy[i] && mwt[i] > 0) sel = i;
          end
        end
        if (sel >= 0) mcr[sel]--;
      end
      if (sel >= 0) exp_q.push_back(sel);
    end
  endtask

  task automatic release_link();
    eop_drv = 1'b1;
    @(negedge clk_i);
    eop_drv = 1'b0;
  endtask

  task automatic finish_phase();
    wait (exp_q.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic enq(input int cos);
    @(negedge clk_i);
    enq_valid_i = 1'b1;
    enq_cos_i   = 3'(cos);
    #(CLK/4);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) mcr[i] = 0;
    repeat (3) @(negedge clk_i);
    check(grant_valid_o == 1'b0, "R11 reset grant", grant_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // enqueue path
    cos_map_i = 16'hFA50;
    for (int c = 0; c < 8; c++) begin
      enq(c);
      check(enq_qid_o == 2'(c/2), "R1 map A", enq_qid_o, c/2);
    end
    cos_map_i = 16'hE4E4;
    for (int c = 0; c < 8; c++) begin
      enq(c);
      check(enq_qid_o == 2'(c%4), "R1 map B", enq_qid_o, c%4);
    end
    cos_map_i = 16'hFA50;
    thr_lo_i = {10'd100, 10'd5, 10'd10};
    thr_hi_i = {10'd200, 10'd6, 10'd20};
    prob_i   = {8'd0, 8'd0, 8'd255};
    occ_i    = {10'd0, 10'd0, 10'd9};
    for (int k = 0; k < 5; k++) begin
      enq(0);
      check(enq_drop_o == 1'b0, "R7 below low", enq_drop_o, 0);
    end
    prob_i = {8'd0, 8'd0, 8'd0};
    occ_i  = {10'd0, 10'd0, 10'd20};
    enq(1);
    check(enq_drop_o == 1'b1, "R8 at high", enq_drop_o, 1);
    occ_i  = {10'd0, 10'd6, 10'd1023};
    enq(0);
    check(enq_drop_o == 1'b1, "R8 full", enq_drop_o, 1);
    enq(2);
    check(enq_drop_o == 1'b1, "R8 queue1 at high", enq_drop_o, 1);
    occ_i  = {10'd0, 10'd0, 10'd19};
    for (int k = 0; k < 5; k++) begin
      enq(0);
      check(enq_drop_o == 1'b0, "R9 prob zero", enq_drop_o, 0);
    end
    for (int p = 128; p <= 255; p += 127) begin
      int nd;
      nd = 0;
      prob_i = {8'd0, 8'd0, 8'(p)};
      occ_i  = {10'd0, 10'd0, 10'd15};
      for (int k = 0; k < 255; k++) begin
        enq(1);
        if (enq_drop_o) nd++;
      end
      check(nd == p - 1, "R9 in-band drop count", nd, p - 1);
    end
    occ_i = {10'd1023, 10'd1023, 10'd1023};
    enq(6);
    check(enq_qid_o == 2'd3 && enq_drop_o == 1'b0, "R10 top queue kept", enq_drop_o, 0);
    enq(7);
    check(enq_drop_o == 1'b0, "R10 top queue kept", enq_drop_o, 0);
    @(negedge clk_i);
    enq_valid_i = 1'b0;

    // scheduler, phase 1: weights 2,1,3, lower queues ready (link idle)
    set_wt(2, 1, 3);
    push_n(12, 4'b0111);
    q_ready_i = 4'b0111;
    finish_phase();

    // link held busy with strict queue ready: no grant (R6)
    q_ready_i = 4'b1000;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      check(grant_valid_o == 1'b0, "R6 busy no grant", grant_valid_o, 0);
    end
    push_n(1, 4'b1000);
    release_link();
    finish_phase();

    // R2 strict among all ready
    push_n(3, 4'b1111);
    q_ready_i = 4'b1111;
    release_link();
    finish_phase();

    // R4 zero weight excluded
    set_wt(1, 0, 2);
    push_n(9, 4'b0111);
    q_ready_i = 4'b0111;
    release_link();
    finish_phase();

    // R3 sparse ready, early new round
    set_wt(3, 5, 1);
    push_n(8, 4'b0101);
    q_ready_i = 4'b0101;
    release_link();
    finish_phase();

    // R5 nothing ready
    q_ready_i = 4'b0000;
    release_link();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      check(grant_valid_o == 1'b0, "R5 idle no grant", grant_valid_o, 0);
    end

    // R3 start from idle link
    set_wt(1, 1, 1);
    push_n(6, 4'b0110);
    q_ready_i = 4'b0110;
    finish_phase();
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R3 all grants seen", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule